// File: doc/BRIEF.md
# Interrupt Acknowledge Hold Controller

This block makes the accept-or-defer decision for a pending maskable interrupt at every instruction boundary of a CPU pipeline. The retire stage sends a one-cycle strobe each time an instruction completes. With the strobe come four flags: one marks the retiring instruction as belonging to the hold class, one marks it as the software break, one carries the global interrupt-enable flag, and one reports that an arbitrated request is pending.

Hold-class instructions change the program status word, return from interrupts, enable or disable interrupts, conditionally skip, multiply or multiply-accumulate, or write an interrupt flag, mask or priority register. No acknowledge is given at the boundary that ends a hold-class instruction, so the earliest acknowledge comes at the end of the next instruction. A run of hold-class instructions defers acceptance until the first ordinary instruction retires.

The software break is not hold-class. Taking it clears the interrupt-enable flag, though. The block therefore locks out acceptance from the break boundary until it has seen the enable flag low. The enable flag may lag in the status register, and the lock covers that lag. A granted acknowledge is a single-cycle pulse, and the core uses it to start saving the status word and program counter and to jump to the service routine.

Top module: `irq_hold_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ack_o` is low and the break lock is clear. With the lock clear, the first qualifying boundary after reset is acknowledged.
- R2: `ack_o` is high for exactly the one cycle after a clock edge at which all of the following hold: `retire_i`=1, `ie_i`=1, `req_i`=1, `hold_cls_i`=0, `swbrk_i`=0, the break lock is clear, and no acknowledge was issued in the cycle before.
- R3: A boundary with `hold_cls_i`=1 never produces an acknowledge, whatever the other inputs are.
- R4: If a request is pending when a hold-class instruction retires, the acknowledge comes at the next boundary that has `hold_cls_i`=0, provided the request is still pending and interrupts are still enabled.
- R5: Back-to-back hold-class boundaries each defer acceptance again. No acknowledge is given until a boundary with `hold_cls_i`=0 occurs.
- R6: `ack_o` stays low after any cycle in which `retire_i`=0.
- R7: A boundary with `swbrk_i`=1 never produces an acknowledge.
- R8: A boundary with `swbrk_i`=1 sets the break lock when `ie_i`=1. While the lock is set, no acknowledge is given. The lock clears at the first clock edge at which `ie_i`=0.
- R9: With `ie_i`=0, as after a disable-interrupt instruction, no boundary produces an acknowledge.
- R10: `ack_o` is never high in two consecutive cycles, even when qualifying boundaries retire on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One-cycle strobe at an instruction boundary |
| hold_cls_i | input | 1 | The retiring instruction is hold-class |
| swbrk_i | input | 1 | The retiring instruction is the software break |
| ie_i | input | 1 | Global maskable interrupt enable flag |
| req_i | input | 1 | An arbitrated maskable request is pending |
| ack_o | output | 1 | One-cycle acknowledge that starts the save-and-vector sequence |

## Verification
The bench sweeps every combination of the boundary flags, first with the break lock clear and then with it set. It then runs the key orderings:
- A request pending at a hold boundary: a design that ignored the hold would acknowledge one instruction early.
- A chain of hold boundaries: a design with a fixed one-instruction shadow would acknowledge at the second hold boundary.
- A break retired while the enable flag still reads high: a design without the lock would acknowledge at the very next boundary.
- Consecutive qualifying boundaries: a design without the back-to-back guard would stretch the acknowledge to two cycles.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    typedef struct packed {
        logic retire;
        logic hold;
        logic brk;
        logic ie;
        logic req;
    } irqh_bnd_t;

    typedef struct packed {
        logic ack;
        logic lock;
    } irqh_state_t;

    localparam irqh_state_t IRQH_RESET = '{ack: 1'b0, lock: 1'b0};

endpackage

// File: rtl/irqh_qualify.sv
module irqh_qualify
    import irqh_pkg::*;
#(
    parameter bit GUARD_B2B = 1'b1
) (
    input  irqh_bnd_t bnd_i,
    input  logic      lock_i,
    input  logic      ack_prev_i,
    output logic      grant_o
);
    logic boundary_ok;
    logic enabled;
    logic guard_ok;

    always_comb begin
        boundary_ok = bnd_i.retire & ~bnd_i.hold & ~bnd_i.brk;
        enabled     = bnd_i.ie & ~lock_i;
    end

    generate
        if (GUARD_B2B) begin : g_guard
            always_comb guard_ok = ~ack_prev_i;
        end else begin : g_noguard
            logic unused_prev;
            always_comb begin
                unused_prev = ack_prev_i;
                guard_ok    = 1'b1;
            end
        end
    endgenerate

    always_comb grant_o = boundary_ok & enabled & bnd_i.req & guard_ok;

endmodule

// File: rtl/irqh_lock.sv
module irqh_lock
    import irqh_pkg::*;
(
    input  irqh_bnd_t bnd_i,
    input  logic      lock_q_i,
    output logic      lock_d_o
);
    always_comb begin
        lock_d_o = lock_q_i;
        if (bnd_i.retire && bnd_i.brk) begin
            lock_d_o = 1'b1;
        end
        if (!bnd_i.ie) begin
            lock_d_o = 1'b0;
        end
    end
endmodule

// File: rtl/irq_hold_gate.sv
module irq_hold_gate
    import irqh_pkg::*;
#(
    parameter bit GUARD_B2B = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_i,
    input  logic hold_cls_i,
    input  logic swbrk_i,
    input  logic ie_i,
    input  logic req_i,
    output logic ack_o
);
    irqh_bnd_t   bnd;
    irqh_state_t st_d, st_q;
    logic        grant;
    logic        lock_d;

    always_comb begin
        bnd.retire = retire_i;
        bnd.hold   = hold_cls_i;
        bnd.brk    = swbrk_i;
        bnd.ie     = ie_i;
        bnd.req    = req_i;
    end

    irqh_qualify #(.GUARD_B2B(GUARD_B2B)) u_qual (
        .bnd_i      (bnd),
        .lock_i     (st_q.lock),
        .ack_prev_i (st_q.ack),
        .grant_o    (grant)
    );

    irqh_lock u_lock (
        .bnd_i    (bnd),
        .lock_q_i (st_q.lock),
        .lock_d_o (lock_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = grant;
        st_d.lock = lock_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IRQH_RESET;
        else        st_q <= st_d;
    end

    assign ack_o = st_q.ack;

endmodule

// File: rtl/irq_hold_gate_chk.sv
module irq_hold_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic retire_i,
    input logic hold_cls_i,
    input logic swbrk_i,
    input logic ie_i,
    input logic req_i,
    input logic lock_q,
    input logic ack_o
);
    a_r3_hold_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && hold_cls_i) |=> !ack_o);
    a_r6_no_retire_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_i |=> !ack_o);
    a_r7_brk_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && swbrk_i) |=> !ack_o);
    a_r8_locked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> !ack_o);
    a_r8_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_i |=> !lock_q);
    a_r9_disabled_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_i |=> !ack_o);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    a_r2_ack_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(req_i && ie_i));
endmodule

bind irq_hold_gate irq_hold_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_i   (retire_i),
    .hold_cls_i (hold_cls_i),
    .swbrk_i    (swbrk_i),
    .ie_i       (ie_i),
    .req_i      (req_i),
    .lock_q     (st_q.lock),
    .ack_o      (ack_o)
);

// File: tb/irq_hold_gate_tb_top.sv
`timescale 1ns/1ps
module irq_hold_gate_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retire_i = 1'b0, hold_cls_i = 1'b0, swbrk_i = 1'b0, ie_i = 1'b0, req_i = 1'b0;
    logic ack_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic  m_lock = 1'b0;
    logic  m_ack  = 1'b0;
    string m_tag  = "R1";

    always #2 clk = ~clk;

    irq_hold_gate dut_i (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .hold_cls_i(hold_cls_i),
        .swbrk_i(swbrk_i), .ie_i(ie_i), .req_i(req_i), .ack_o(ack_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ack_o=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: first check the output of the last edge, then drive new inputs.
    task automatic cyc(input logic r, input logic h, input logic b,
                       input logic e, input logic q, input string tag);
        logic nack;
        logic nlock;
        @(negedge clk);
        chk(ack_o, m_ack, m_tag);
        retire_i = r; hold_cls_i = h; swbrk_i = b; ie_i = e; req_i = q;
        nack  = r & ~h & ~b & e & ~m_lock & q & ~m_ack;
        nlock = (!e) ? 1'b0 : ((r & b) ? 1'b1 : m_lock);
        m_ack  = nack;
        m_lock = nlock;
        m_tag  = tag;
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ack_o, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        // R1: first qualifying boundary after reset is acknowledged (lock clear)
        cyc(1, 0, 0, 1, 1, "R1 first boundary");
        cyc(0, 0, 0, 1, 1, "R6 idle");
        // R6: no retire, no ack
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, "R6 no retire");
        // R2/R3/R7/R9 exhaustive sweep of boundary flags, lock clear then set
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 16; v++) begin
                cyc(0, 0, 0, 0, 0, "R8 clear lock");
                if (pass == 1) cyc(1, 0, 1, 1, 0, "R8 set lock");
                cyc(1, v[3], v[2], v[1], v[0], pass == 0 ? "R2 sweep" : "R8 sweep locked");
                cyc(0, 0, 0, v[1], 0, "R6 gap");
            end
        end
        cyc(0, 0, 0, 0, 0, "R8 clear");
        // R4: request during hold instruction, acked after the next instruction
        cyc(1, 1, 0, 1, 1, "R3 hold boundary");
        cyc(0, 0, 0, 1, 1, "R4 gap");
        cyc(1, 0, 0, 1, 1, "R4 next boundary");
        cyc(0, 0, 0, 1, 1, "R4 after");
        // R5: back-to-back hold instructions
        cyc(1, 1, 0, 1, 1, "R5 hold 1");
        cyc(1, 1, 0, 1, 1, "R5 hold 2");
        cyc(0, 0, 0, 1, 1, "R5 gap");
        cyc(1, 1, 0, 1, 1, "R5 hold 3");
        cyc(1, 0, 0, 1, 1, "R5 release");
        cyc(0, 0, 0, 1, 1, "R5 after");
        // R8: BRK with stale IE high, lock holds until IE seen low
        cyc(1, 0, 1, 1, 1, "R7 brk boundary");
        cyc(1, 0, 0, 1, 1, "R8 locked 1");
        cyc(1, 1, 0, 1, 1, "R8 locked 2");
        cyc(1, 0, 0, 1, 1, "R8 locked 3");
        cyc(0, 0, 0, 0, 1, "R8 ie low");
        cyc(1, 0, 0, 1, 1, "R8 released");
        cyc(0, 0, 0, 1, 1, "R8 after");
        // R9: DI leaves IE low, never acked
        cyc(1, 1, 0, 1, 1, "R9 DI boundary");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 1, "R9 disabled");
        // R10: consecutive qualifying boundaries
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 1, 1, "R10 back-to-back");
        cyc(0, 0, 0, 1, 0, "R10 end");
        cyc(0, 0, 0, 1, 0, "R10 end");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule